// File: doc/BRIEF.md
# Supervisory Reset Pulse Stretcher

This block turns three digital supervision inputs into a clean, stretched system reset. An undervoltage flag from an external supply comparator, an active-low manual reset line and an active-low power-fail flag are first brought into the clock domain through a synchronizer chain. From their synchronized values the block forms a single reset request. Reset is held for as long as that request is present. Once it has gone away, reset is held for a further recovery period, counted in clock cycles.

Two conditions shape the request. While the power-fail flag is low, the manual reset line is masked, so a falling supply cannot also trip a manual reset. Any fresh request during the recovery period clears the count, so recovery always runs in full from the last release.

The block drives registered active-low and active-high reset outputs that are exact complements of each other. It also drives a reset-active status that a companion watchdog uses to keep its own timer cleared. The synchronous block reset models power-on. It forces reset asserted and clears the timer, and a full recovery period follows its release.

Top module: `reset_stretcher`

## Requirements
- R1: While `rst` is high, `sys_rst` is 1, `sys_rst_n` is 0 and `reset_active` is 1. With all sources idle, reset stays asserted after the REC_CYCLES-1th rising edge following the release of `rst`, and is deasserted after the REC_CYCLES-th.
- R2: With `supply_low` high (active high), reset is asserted after SYNC_STAGES+1 rising edges and stays asserted for as long as the flag remains high.
- R3: After the last source releases before rising edge k, reset stays asserted through edge k+SYNC_STAGES+REC_CYCLES-2 and is deasserted after edge k+SYNC_STAGES+REC_CYCLES-1.
- R4: With `man_rst_n` low (active low) and `pfail_n` high, reset is asserted after SYNC_STAGES+1 rising edges and stays asserted while the line is low.
- R5: A request lasting a single clock cycle, from either the manual line or the undervoltage flag, still produces a full recovery period with the timing of R3.
- R6: A new undervoltage request during the recovery period restarts the recovery period from zero, timed from the new release.
- R7: While `pfail_n` is low, a low `man_rst_n` has no effect, and reset stays deasserted.
- R8: `pfail_n` low on its own never asserts reset.
- R9: `sys_rst_n` is always the inverse of `sys_rst`, and `reset_active` always equals `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset (power-on model) |
| supply_low | input | 1 | Undervoltage flag, high when the supply is below threshold |
| man_rst_n | input | 1 | Manual reset request, active low |
| pfail_n | input | 1 | Power-fail flag, low while a failure is signalled; masks the manual line |
| sys_rst_n | output | 1 | Stretched reset, active low |
| sys_rst | output | 1 | Stretched reset, active high |
| reset_active | output | 1 | Status for a companion watchdog, high while reset is asserted |

## Verification
The assertions assume that the block reset is driven high from time zero and that `rst` is synchronous to `clk`. The three supervision inputs may change at any time, because the synchronizer absorbs them. The stimulus changes every input only at the falling clock edge and holds each value for whole cycles, so the number of edges that latency spans is exact. The bench uses a short recovery count, so every release can be timed to a single edge on both sides. The gating case changes the power-fail flag and the manual line on the same falling edge. Both pass through equal-length synchronizers, so no one-cycle request can slip through between them.

// File: rtl/reset_stretcher_pkg.sv
package reset_stretcher_pkg;

  // synchronized supervision sources
  typedef struct packed {
    logic undervolt;   // 1 = supply below threshold
    logic manual_n;    // 0 = manual reset request
    logic pfail_n;     // 0 = power failing, masks manual
  } sup_src_t;

  localparam int unsigned SRC_W = $bits(sup_src_t);

  // value each source takes while idle (also synchronizer reset value)
  localparam sup_src_t SRC_IDLE = '{undervolt: 1'b0, manual_n: 1'b1, pfail_n: 1'b1};

endpackage

// File: rtl/reset_stretcher_sync.sv
module reset_stretcher_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL[b];
        else     chain <= d[b];
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/reset_stretcher_combine.sv
module reset_stretcher_combine
  import reset_stretcher_pkg::*;
(
  input  sup_src_t src,
  output logic     req
);

  logic manual_req;

  // manual line is masked whenever the power-fail flag is low
  always_comb begin
    manual_req = ~src.manual_n & src.pfail_n;
    req        = src.undervolt | manual_req;
  end

endmodule

// File: rtl/reset_stretcher_timer.sv
module reset_stretcher_timer #(
  parameter int unsigned REC_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic hold_nxt,
  output logic hold_q
);

  localparam int unsigned CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(REC_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    hold_nxt = hold_q;
    cnt_nxt  = cnt_q;
    if (req) begin
      hold_nxt = 1'b1;
      cnt_nxt  = '0;
    end else if (hold_q) begin
      if (cnt_q == LAST) begin
        hold_nxt = 1'b0;
        cnt_nxt  = '0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  // independent run length of request-free cycles, saturating at FULL
  logic [CNT_W-1:0] quiet_run;
  always_ff @(posedge clk) begin
    if (rst || req)          quiet_run <= '0;
    else if (quiet_run != FULL) quiet_run <= quiet_run + 1'b1;
  end

  a_r1_block_reset_holds: assert property (@(posedge clk) rst |=> hold_q);
  a_r2_req_asserts: assert property (@(posedge clk) disable iff (rst) req |=> hold_q);
  a_r3_full_recovery: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> (quiet_run == FULL));
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst) cnt_q < FULL);
  a_r6_req_restarts: assert property (@(posedge clk) disable iff (rst)
    req |=> (cnt_q == '0));

endmodule

// File: rtl/reset_stretcher_out.sv
module reset_stretcher_out (
  input  logic clk,
  input  logic rst,
  input  logic hold_nxt,
  output logic rst_hi,
  output logic rst_lo_n,
  output logic active
);

  // separate flops for each output, all loaded from the same next state
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_hi   <= 1'b1;
      rst_lo_n <= 1'b0;
      active   <= 1'b1;
    end else begin
      rst_hi   <= hold_nxt;
      rst_lo_n <= ~hold_nxt;
      active   <= hold_nxt;
    end
  end

  a_r9_complement: assert property (@(posedge clk) disable iff (rst) rst_lo_n == ~rst_hi);
  a_r9_status_match: assert property (@(posedge clk) disable iff (rst) active == rst_hi);

endmodule

// File: rtl/reset_stretcher.sv
module reset_stretcher
  import reset_stretcher_pkg::*;
#(
  parameter int unsigned REC_CYCLES  = 50_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic man_rst_n,
  input  logic pfail_n,
  output logic sys_rst_n,
  output logic sys_rst,
  output logic reset_active
);

  sup_src_t raw_src, sync_src;
  logic     req, hold_nxt, hold_q;

  always_comb begin
    raw_src.undervolt = supply_low;
    raw_src.manual_n  = man_rst_n;
    raw_src.pfail_n   = pfail_n;
  end

  reset_stretcher_sync #(
    .WIDTH(SRC_W), .STAGES(SYNC_STAGES), .RESET_VAL(SRC_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_src), .q(sync_src)
  );

  reset_stretcher_combine u_combine (
    .src(sync_src), .req(req)
  );

  reset_stretcher_timer #(
    .REC_CYCLES(REC_CYCLES)
  ) u_timer (
    .clk(clk), .rst(rst), .req(req), .hold_nxt(hold_nxt), .hold_q(hold_q)
  );

  reset_stretcher_out u_out (
    .clk(clk), .rst(rst), .hold_nxt(hold_nxt),
    .rst_hi(sys_rst), .rst_lo_n(sys_rst_n), .active(reset_active)
  );

  a_r9_out_tracks_state: assert property (@(posedge clk) disable iff (rst) sys_rst == hold_q);
  a_r7_masked_manual: assert property (@(posedge clk) disable iff (rst)
    (!sync_src.pfail_n && !sync_src.undervolt) |-> !req);

endmodule

// File: tb/reset_stretcher_bench.sv
`timescale 1ns/1ps
module reset_stretcher_bench;

  localparam int unsigned REC  = 12;
  localparam int unsigned SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b0;
  logic man_rst_n = 1'b1;
  logic pfail_n = 1'b1;
  logic sys_rst_n, sys_rst, reset_active;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reset_stretcher #(.REC_CYCLES(REC), .SYNC_STAGES(SYNC)) u_reset_stretcher (
    .clk(clk), .rst(rst), .supply_low(supply_low), .man_rst_n(man_rst_n),
    .pfail_n(pfail_n), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst),
    .reset_active(reset_active)
  );

  typedef struct packed {
    logic       uv;
    logic       mr_n;
    logic       pf_n;
    logic [7:0] edges;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [0:11] = '{
    '{1'b0, 1'b1, 1'b1, 8'd4,  1'b0, 4'd3},   // R3 idle, released
    '{1'b1, 1'b1, 1'b1, 8'd3,  1'b1, 4'd2},   // R2 latency SYNC+1
    '{1'b1, 1'b1, 1'b1, 8'd20, 1'b1, 4'd2},   // R2 held
    '{1'b0, 1'b1, 1'b1, 8'd13, 1'b1, 4'd3},   // R3 last asserted edge
    '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd3},   // R3 released
    '{1'b0, 1'b0, 1'b1, 8'd3,  1'b1, 4'd4},   // R4 latency
    '{1'b0, 1'b0, 1'b1, 8'd10, 1'b1, 4'd4},   // R4 held
    '{1'b0, 1'b1, 1'b1, 8'd13, 1'b1, 4'd3},   // R3 manual release
    '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd3},   // R3
    '{1'b0, 1'b0, 1'b0, 8'd20, 1'b0, 4'd7},   // R7 masked manual
    '{1'b0, 1'b1, 1'b0, 8'd5,  1'b0, 4'd8},   // R8 power-fail alone
    '{1'b0, 1'b1, 1'b1, 8'd4,  1'b0, 4'd8}    // R8 return to idle
  };

  task automatic check_out(input logic exp, input int r);
    n_checks++;
    if (sys_rst !== exp || sys_rst_n !== ~exp || reset_active !== exp) begin
      n_fail++;
      $display("FAIL R%0d: sys_rst=%b sys_rst_n=%b reset_active=%b expected %b/%b/%b",
               r, sys_rst, sys_rst_n, reset_active, exp, ~exp, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // single-cycle request then full-period timing check (R5, R6)
  task automatic pulse_check(input bit use_uv, input int r);
    @(negedge clk);
    if (use_uv) supply_low = 1'b1; else man_rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    supply_low = 1'b0;
    man_rst_n  = 1'b1;
    edges(SYNC + REC - 1);
    check_out(1'b1, r);
    edges(1);
    check_out(1'b0, r);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    // R1: block reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out(1'b1, 1);
    rst = 1'b0;
    edges(REC - 1);
    check_out(1'b1, 1);
    edges(1);
    check_out(1'b0, 1);

    // vector table
    for (int v = 0; v < 12; v++) begin
      supply_low = VEC[v].uv;
      man_rst_n  = VEC[v].mr_n;
      pfail_n    = VEC[v].pf_n;
      edges(int'(VEC[v].edges));
      check_out(VEC[v].exp, int'(VEC[v].req));
    end

    // R5: one-cycle manual and undervoltage pulses
    pulse_check(1'b0, 5);
    pulse_check(1'b1, 5);

    // R6: new undervoltage mid-recovery restarts the period
    @(negedge clk);
    supply_low = 1'b1;
    edges(5);
    supply_low = 1'b0;
    edges(8);
    check_out(1'b1, 6);
    pulse_check(1'b1, 6);

    // R1: block reset during normal operation
    rst = 1'b1;
    edges(1);
    check_out(1'b1, 1);
    rst = 1'b0;
    edges(REC);
    check_out(1'b0, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule